// File: doc/BRIEF.md
# Addressed Almost-Full Status Sector Selector

This block sits on the write side of a multi-queue buffer. It shares one narrow status bus among many queues. Each queue raises an almost-full status bit. The block shows one group of eight of those bits at a time on an 8-bit bus. The groups are called sectors: with sixteen queue slots there are two sectors, queues 0–7 and queues 8–15. The buffer logic outside the block supplies the status vector.

The user picks a sector with a strobe and a small address word. The upper bits of the address name a device and the low bit names a sector. Several of these blocks can share one physical bus. Only the block whose static device ID matches the address accepts the selection and enables its output. Every other block drops its output enable, which stands for high impedance.

A mode pin is sampled while reset is held. When it is low, the addressed selection described above is active. When it is high, strobes are ignored and sector 0 is shown with the output enabled. The strobe shares its cycle with the write-queue selection, and the queue selection always wins.

Top module: `sectbus_flag_sel`

## Requirements
- R1: If `mode_pin` is high on the last reset cycle, every strobe is ignored afterwards: `flag_bus` shows sector 0 and `bus_oe` stays 1 until the next reset. If `mode_pin` is low, addressed selection is active.
- R2: After reset the selected sector is 0. `bus_oe` is 1 if `dev_id` is 0 or `mode_pin` was high, and 0 otherwise.
- R3: A selection is accepted on a rising edge where `sel_strobe`=1, `wr_qsel`=0 and `wr_addr[3:1]` equals `dev_id`. The sector number is then taken from `wr_addr[0]`, and `bus_oe` becomes 1. From that edge on, the bus shows the new sector. With `sel_strobe` low the selection holds.
- R4: `flag_bus[i]` equals `q_status[8*sector+i]`. It follows `q_status` within the same cycle, with no added register.
- R5: A different sector can be selected on each of several consecutive edges, and each one shows on the bus after its own edge.
- R6: A strobe in a cycle where `wr_qsel` is 1 is ignored. Both the sector and `bus_oe` keep their values.
- R7: An accepted-style strobe whose `wr_addr[3:1]` differs from `dev_id` clears `bus_oe` and leaves the sector unchanged. A later matching strobe enables the bus again.
- R8: With `NUM_QUEUES` of 8 or fewer, sector 0 is shown whatever the address says.
- R9: Bus bits whose queue index is at or above `NUM_QUEUES` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_pin | input | 1 | Sampled during reset: 0 = addressed, 1 = fixed sector 0 |
| q_status | input | QUEUE_SLOTS (16) | Almost-full status, one bit per queue |
| wr_addr | input | ID_W+SEC_W (4) | [3:1] device ID, [0] sector number |
| sel_strobe | input | 1 | Requests a sector selection on this edge |
| wr_qsel | input | 1 | Write-queue selection in this cycle; blocks the strobe |
| dev_id | input | ID_W (3) | Static device identity |
| flag_bus | output | BUS_W (8) | Status of the selected sector |
| bus_oe | output | 1 | Drives the shared bus when 1 |

## Verification
The hardest state to reach is a collision on one edge: the strobe is raised together with a write-queue selection, while the address points at a sector other than the current one. Only then does a lost strobe change nothing that can be observed. The stimulus first moves the block to sector 1 and then strikes with the address set to sector 0 and `wr_qsel` high. It then repeats the collision with a foreign device ID, so that neither the sector nor the enable may move. A second instance built with six queues runs beside the main one, so that the forced sector and the zeroed upper bits can be observed under the same stimulus.

// File: rtl/sectbus_pkg.sv
package sectbus_pkg;

  typedef enum logic {
    MODE_ADDRESSED = 1'b0,
    MODE_FIXED     = 1'b1
  } sel_mode_e;

  // number of sectors that hold at least one configured queue
  function automatic int sectors_needed(input int nq, input int busw);
    return (nq + busw - 1) / busw;
  endfunction

  // a requested sector beyond the configured ones falls back to sector 0
  function automatic int clip_sector(input int req, input int act);
    return (req < act) ? req : 0;
  endfunction

  // queue index carried on bus bit g while sector s is shown
  function automatic int queue_index(input int s, input int g, input int busw);
    return s * busw + g;
  endfunction

endpackage

// File: rtl/sectbus_mode_cap.sv
module sectbus_mode_cap (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_pin,
  output sectbus_pkg::sel_mode_e mode_q
);
  import sectbus_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_pin ? MODE_FIXED : MODE_ADDRESSED;
  end

endmodule

// File: rtl/sectbus_sel.sv
module sectbus_sel #(
  parameter int ID_W    = 3,
  parameter int SEC_W   = 1,
  parameter int ACT_SEC = 2,
  localparam int ADDR_W = ID_W + SEC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_pin,
  input  sectbus_pkg::sel_mode_e mode_q,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic                   sel_strobe,
  input  logic                   wr_qsel,
  input  logic [ID_W-1:0]        dev_id,
  output logic [SEC_W-1:0]       sector_q,
  output logic                   own_q,
  output logic                   accept_ev,
  output logic                   foreign_ev,
  output logic                   blocked_ev
);
  import sectbus_pkg::*;

  logic              req_ev;
  logic              live_ev;
  logic              id_hit;
  logic [SEC_W-1:0]  sector_next;

  assign req_ev     = (mode_q == MODE_ADDRESSED) && sel_strobe;
  assign blocked_ev = req_ev && wr_qsel;
  assign live_ev    = req_ev && !wr_qsel;
  assign id_hit     = (wr_addr[ADDR_W-1:SEC_W] == dev_id);
  assign accept_ev  = live_ev && id_hit;
  assign foreign_ev = live_ev && !id_hit;

  assign sector_next = SEC_W'(clip_sector(int'(wr_addr[SEC_W-1:0]), ACT_SEC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sector_q <= '0;
      own_q    <= mode_pin || (dev_id == '0);
    end else if (accept_ev) begin
      sector_q <= sector_next;
      own_q    <= 1'b1;
    end else if (foreign_ev) begin
      own_q    <= 1'b0;
    end
  end

endmodule

// File: rtl/sectbus_mux.sv
module sectbus_mux #(
  parameter int NUM_QUEUES  = 16,
  parameter int QUEUE_SLOTS = 16,
  parameter int BUS_W       = 8,
  parameter int TOT_SEC     = 2,
  parameter int SEC_W       = 1
) (
  input  logic [QUEUE_SLOTS-1:0] q_status,
  input  logic [SEC_W-1:0]       sector_q,
  output logic [BUS_W-1:0]       flag_bus
);
  import sectbus_pkg::*;

  logic [TOT_SEC-1:0] column [BUS_W];

  for (genvar g = 0; g < BUS_W; g++) begin : g_bit
    for (genvar s = 0; s < TOT_SEC; s++) begin : g_sec
      localparam int QIDX = queue_index(s, g, BUS_W);
      if (QIDX < NUM_QUEUES) begin : g_live
        assign column[g][s] = q_status[QIDX];
      end else begin : g_unused
        assign column[g][s] = 1'b0;
      end
    end
    assign flag_bus[g] = column[g][sector_q];
  end

endmodule

// File: rtl/sectbus_flag_sel.sv
module sectbus_flag_sel #(
  parameter int NUM_QUEUES  = 16,
  parameter int QUEUE_SLOTS = 16,
  parameter int BUS_W       = 8,
  parameter int ID_W        = 3,
  localparam int TOT_SEC    = QUEUE_SLOTS / BUS_W,
  localparam int SEC_W      = (TOT_SEC > 1) ? $clog2(TOT_SEC) : 1,
  localparam int ADDR_W     = ID_W + SEC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_pin,
  input  logic [QUEUE_SLOTS-1:0] q_status,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic                   sel_strobe,
  input  logic                   wr_qsel,
  input  logic [ID_W-1:0]        dev_id,
  output logic [BUS_W-1:0]       flag_bus,
  output logic                   bus_oe
);
  import sectbus_pkg::*;

  localparam int ACT_SEC = sectors_needed(NUM_QUEUES, BUS_W);

  sel_mode_e         mode_q;
  logic [SEC_W-1:0]  sector_q;
  logic              own_q;
  logic              accept_ev;
  logic              foreign_ev;
  logic              blocked_ev;

  sectbus_mode_cap u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_pin (mode_pin),
    .mode_q   (mode_q)
  );

  sectbus_sel #(
    .ID_W    (ID_W),
    .SEC_W   (SEC_W),
    .ACT_SEC (ACT_SEC)
  ) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_pin   (mode_pin),
    .mode_q     (mode_q),
    .wr_addr    (wr_addr),
    .sel_strobe (sel_strobe),
    .wr_qsel    (wr_qsel),
    .dev_id     (dev_id),
    .sector_q   (sector_q),
    .own_q      (own_q),
    .accept_ev  (accept_ev),
    .foreign_ev (foreign_ev),
    .blocked_ev (blocked_ev)
  );

  sectbus_mux #(
    .NUM_QUEUES  (NUM_QUEUES),
    .QUEUE_SLOTS (QUEUE_SLOTS),
    .BUS_W       (BUS_W),
    .TOT_SEC     (TOT_SEC),
    .SEC_W       (SEC_W)
  ) u_mux (
    .q_status (q_status),
    .sector_q (sector_q),
    .flag_bus (flag_bus)
  );

  assign bus_oe = own_q;

endmodule

// File: rtl/sectbus_chk.sv
module sectbus_chk #(
  parameter int SEC_W  = 1,
  parameter int ADDR_W = 4,
  parameter bit MULTI  = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input sectbus_pkg::sel_mode_e mode_q,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic                   sel_strobe,
  input logic                   wr_qsel,
  input logic [SEC_W-1:0]       sector_q,
  input logic                   accept_ev,
  input logic                   foreign_ev,
  input logic                   blocked_ev,
  input logic                   bus_oe
);
  import sectbus_pkg::*;

  // R3
  take_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && MULTI) |=> (bus_oe && sector_q == $past(wr_addr[SEC_W-1:0])));

  // R6
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_strobe && wr_qsel) |=> ($stable(sector_q) && $stable(bus_oe)));

  // R6
  blocked_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_ev |-> (!accept_ev && !foreign_ev));

  // R7
  foreign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    foreign_ev |=> (!bus_oe && $stable(sector_q)));

  // R1
  fixed_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FIXED) |-> (bus_oe && sector_q == '0));

  // R8
  few_queues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!MULTI) |-> (sector_q == '0));

  // R2
  reset_sector_chk: assert property (@(posedge clk)
    (rst_n && $rose(rst_n)) |-> (sector_q == '0));

endmodule

bind sectbus_flag_sel sectbus_chk #(
  .SEC_W  (SEC_W),
  .ADDR_W (ADDR_W),
  .MULTI  (ACT_SEC > 1)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_q     (mode_q),
  .wr_addr    (wr_addr),
  .sel_strobe (sel_strobe),
  .wr_qsel    (wr_qsel),
  .sector_q   (sector_q),
  .accept_ev  (accept_ev),
  .foreign_ev (foreign_ev),
  .blocked_ev (blocked_ev),
  .bus_oe     (bus_oe)
);

// File: tb/sectbus_flag_sel_test.sv
`timescale 1ns/1ps
module sectbus_flag_sel_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_pin = 1'b0;
  logic [15:0] q_status = '0;
  logic [3:0]  wr_addr = '0;
  logic        sel_strobe = 1'b0;
  logic        wr_qsel = 1'b0;
  logic [2:0]  dev_id = 3'd2;
  logic [7:0]  bus_big, bus_small;
  logic        oe_big, oe_small;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int ref_mode;
  int ref_sec;
  int ref_own;

  always #2.5 clk = ~clk;

  sectbus_flag_sel uut (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .q_status(q_status),
    .wr_addr(wr_addr), .sel_strobe(sel_strobe), .wr_qsel(wr_qsel),
    .dev_id(dev_id), .flag_bus(bus_big), .bus_oe(oe_big)
  );

  sectbus_flag_sel #(.NUM_QUEUES(6)) uut_small (
    .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .q_status(q_status),
    .wr_addr(wr_addr), .sel_strobe(sel_strobe), .wr_qsel(wr_qsel),
    .dev_id(dev_id), .flag_bus(bus_small), .bus_oe(oe_small)
  );

  function automatic logic [7:0] expect_bus(int nq, int sec, logic [15:0] st);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      int q;
      q = sec * 8 + i;
      r[i] = (q < nq) ? st[q] : 1'b0;
    end
    return r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(req, bus_big, expect_bus(16, ref_sec, q_status));
    check(req, {7'd0, oe_big}, 8'(ref_own));
    // small instance: sector is forced to 0 (R8), upper bits zero (R9)
    check(req, bus_small, expect_bus(6, 0, q_status));
    check(req, {7'd0, oe_small}, 8'(ref_own));
  endtask

  task automatic do_reset(logic m, logic [2:0] id);
    rst_n = 1'b0; mode_pin = m; dev_id = id;
    sel_strobe = 1'b0; wr_qsel = 1'b0;
    repeat (2) @(posedge clk);
    ref_mode = m;
    ref_sec = 0;
    ref_own = (m || id == 3'd0) ? 1 : 0;
    @(negedge clk);
    rst_n = 1'b1;
    mode_pin = ~m;
    compare_all("R2 reset state");
  endtask

  // drive one cycle of inputs, model the edge, compare after it
  task automatic tick(logic st, logic [2:0] id, logic sec, logic qs,
                      logic [15:0] stat, string req);
    sel_strobe = st; wr_addr = {id, sec}; wr_qsel = qs; q_status = stat;
    @(posedge clk);
    if (ref_mode == 0 && st && !qs) begin
      if (id == dev_id) begin ref_sec = sec; ref_own = 1; end
      else ref_own = 0;
    end
    @(negedge clk);
    sel_strobe = 1'b0; wr_qsel = 1'b0;
    compare_all(req);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // addressed mode, device 2: output starts disabled
    do_reset(1'b0, 3'd2);
    tick(0, 3'd2, 1'b1, 0, 16'hA55A, "R3 no strobe holds");
    tick(1, 3'd2, 1'b1, 0, 16'hA55A, "R3 select sector 1");
    tick(0, 3'd0, 1'b0, 0, 16'h3C81, "R4 status pattern");
    // same-cycle status change shows without a clock edge
    q_status = 16'hF00F; #0.5;
    compare_all("R4 combinational follow");
    tick(1, 3'd2, 1'b0, 0, 16'h1234, "R3 select sector 0");
    // consecutive selections
    tick(1, 3'd2, 1'b1, 0, 16'hBEEF, "R5 back-to-back 1");
    tick(1, 3'd2, 1'b0, 0, 16'hBEEF, "R5 back-to-back 0");
    tick(1, 3'd2, 1'b1, 0, 16'hBEEF, "R5 back-to-back 1 again");
    // collision: queue selection wins, sector 0 request lost
    tick(1, 3'd2, 1'b0, 1, 16'hC3A5, "R6 strobe with wr_qsel ignored");
    tick(1, 3'd5, 1'b0, 1, 16'hC3A5, "R6 foreign strobe with wr_qsel ignored");
    // another device addressed
    tick(1, 3'd5, 1'b0, 0, 16'h0FF0, "R7 foreign id drops enable");
    tick(0, 3'd2, 1'b0, 0, 16'hFF00, "R7 sector kept while foreign");
    tick(1, 3'd2, 1'b0, 0, 16'hFF00, "R7 matching id re-enables");
    for (int k = 0; k < 16; k++)
      tick(k[0], (k % 3 == 0) ? 3'd1 : 3'd2, k[1], k[2] & k[3],
           16'(k * 16'h1357), "R5 mixed sequence");
    tick(0, 3'd2, 1'b0, 0, 16'hFFFF, "R9 unused bits zero");

    // fixed mode, device 0
    do_reset(1'b1, 3'd0);
    tick(1, 3'd0, 1'b1, 0, 16'h5AA5, "R1 strobe ignored in fixed mode");
    tick(1, 3'd3, 1'b1, 0, 16'h5AA5, "R1 foreign strobe ignored in fixed mode");

    // addressed mode, device 0: enabled from reset
    do_reset(1'b0, 3'd0);
    tick(1, 3'd0, 1'b1, 0, 16'h8001, "R8 small instance stays on sector 0");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule